// File: doc/BRIEF.md
# Up-Counting Interval Timer with Buffered Reload

This block is a 16-bit interval timer that software drives through a small word-addressed register window. A programmable prescaler divides the system clock into counting ticks. On every tick the counter climbs from zero towards an active reload limit. When it passes that limit it returns to zero and raises an update event. The update event is what copies buffered settings into the active timing path and what sets a sticky interrupt flag.

Software can force an update at any time by writing the event-generation register. It can also suppress update events, choose which sources may raise the interrupt flag, and run the timer in a one-shot mode that stops after the next update. A separate debug-halt input can freeze counting, but only when a freeze-enable input allows it. Writes narrower than a half-word are dropped. Reads may be of any width and always return the whole register, zero-extended.

Register offsets (byte addresses): 0x00 control, 0x04 event generation, 0x08 status, 0x0C count, 0x10 prescaler, 0x14 reload. Control bits: 0 run enable, 1 update block, 2 overflow-only flag source, 3 one-shot, 7 reload buffering. `bus_size` encodes 0 byte, 1 half-word, 2 word and 3 reserved.

Top module: `base_timer`

## Requirements
- R1: After reset the control, status, count and prescaler registers read 0, the reload register reads 0xFFFF, and `upd_evt` and `upd_irq` are low.
- R2: Control bits 0 (run enable), 1 (update block), 2 (overflow-only flag source), 3 (one-shot) and 7 (reload buffering) are writable. Every other control bit reads 0.
- R3: While running, the count rises by one on each prescaler tick and returns to 0 on the tick after it equals the active reload. That wrap is an overflow. `upd_evt` is high for exactly the one cycle after each update event.
- R4: The prescaler divides the clock by (prescaler value + 1). A written prescaler value becomes active only at an update event.
- R5: With reload buffering (control bit 7) at 0, a reload write takes effect at once. With it at 1, the new value waits until the next update event. The reload register always reads back the last value written.
- R6: While the update block bit (control bit 1) is 1, no update event occurs and no buffered value is transferred. The counter still wraps at the active reload.
- R7: With control bit 2 at 0, both overflow and software update set the status flag. With it at 1, only overflow sets the flag.
- R8: Writing 1 to bit 0 of the event-generation register (offset 0x04) clears the counter and the prescaler phase at once, and causes an update event unless updates are blocked. That register always reads 0.
- R9: With one-shot (control bit 3) set, hardware clears the run enable bit at the next update event, and counting stops.
- R10: When `dbg_halt` and `dbg_freeze_en` are both high, the count and the prescaler phase hold. When `dbg_freeze_en` is low, `dbg_halt` has no effect.
- R11: Writes with `bus_size` 0 (byte) or 3 (reserved) change no register.
- R12: Status bit 0 is the update flag, and `upd_irq` follows it. Writing 0 to status bit 0 clears the flag and writing 1 leaves it alone. A new set in the same cycle as a clear wins.
- R13: A write to the count register (offset 0x0C) loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_size | input | 2 | Access width: 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| dbg_halt | input | 1 | Debug halt indication |
| dbg_freeze_en | input | 1 | Lets `dbg_halt` freeze counting |
| upd_evt | output | 1 | One-cycle pulse following each update event |
| upd_irq | output | 1 | Level of the sticky update flag |

## Verification
On every cycle the assertions check these local rules:
- the prescaler phase never exceeds its active divisor, and it holds while frozen;
- the count steps by one per tick and lands on zero after an overflow or a software update;
- a blocked update never yields a pulse;
- one-shot drops the enable;
- an overflow-only source ignores software updates;
- narrow writes leave the buffers untouched.

Only the bench scenarios, compared cycle by cycle against a behavioural model, can show the wider timing. That covers when a buffered prescaler or reload actually takes effect across a period boundary, the divided count sequence, the flag's set and clear interplay, and the register read-back after each kind of write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned REG_DW   = 16;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_EGEN = 'h04;
  localparam int unsigned OFS_STAT = 'h08;
  localparam int unsigned OFS_CNT  = 'h0C;
  localparam int unsigned OFS_PSC  = 'h10;
  localparam int unsigned OFS_ARR  = 'h14;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  typedef struct packed {
    logic arpe;   // reload buffering
    logic opm;    // one-shot
    logic urs;    // overflow-only flag source
    logic udis;   // update block
    logic cen;    // run enable
  } ctrl_t;

  function automatic logic width_ok(input logic [1:0] sz);
    return (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

  function automatic ctrl_t ctrl_decode(input logic [REG_DW-1:0] w);
    ctrl_t c;
    c.cen  = w[0];
    c.udis = w[1];
    c.urs  = w[2];
    c.opm  = w[3];
    c.arpe = w[7];
    return c;
  endfunction

  function automatic logic [REG_DW-1:0] ctrl_encode(input ctrl_t c);
    return {8'h00, c.arpe, 3'b000, c.opm, c.urs, c.udis, c.cen};
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic              uev,
  output ctrl_t             ctrl,
  output logic [PSC_W-1:0]  psc_buf,
  output logic [CNT_W-1:0]  arr_buf,
  output logic [CNT_W-1:0]  arr_act,
  output logic              sw_ug,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              stat_clr
);

  logic wr_ok;
  logic wr_ctrl, wr_egen, wr_stat, wr_cnt, wr_psc, wr_arr;
  logic wdata_unused;

  assign wr_ok   = bus_we && width_ok(bus_size);
  assign wr_ctrl = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_egen = wr_ok && (bus_addr == ADDR_W'(OFS_EGEN));
  assign wr_stat = wr_ok && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_cnt  = wr_ok && (bus_addr == ADDR_W'(OFS_CNT));
  assign wr_psc  = wr_ok && (bus_addr == ADDR_W'(OFS_PSC));
  assign wr_arr  = wr_ok && (bus_addr == ADDR_W'(OFS_ARR));

  assign sw_ug        = wr_egen && bus_wdata[0];
  assign stat_clr     = wr_stat && !bus_wdata[0];
  assign cnt_load     = wr_cnt;
  assign cnt_load_val = bus_wdata[CNT_W-1:0];
  assign wdata_unused = ^bus_wdata[31:REG_DW];

  // Control: bus write first, then the one-shot hardware clear overrides.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_decode(bus_wdata[REG_DW-1:0]);
      if (uev && ctrl.opm) ctrl.cen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_buf <= '0;
      arr_buf <= '1;
      arr_act <= '1;
    end else begin
      if (wr_psc) psc_buf <= bus_wdata[PSC_W-1:0];
      if (wr_arr) arr_buf <= bus_wdata[CNT_W-1:0];
      if (uev) arr_act <= arr_buf;
      if (wr_arr && !ctrl.arpe) arr_act <= bus_wdata[CNT_W-1:0];
    end
  end

  a_r11_narrow_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !width_ok(bus_size)) |=> ($stable(psc_buf) && $stable(arr_buf)));

  a_r9_one_shot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (uev && ctrl.opm) |=> !ctrl.cen);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             uev,
  input  logic [PSC_W-1:0] psc_buf,
  output logic             tick
);

  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] psc_act;

  function automatic logic [PSC_W-1:0] phase_next(input logic [PSC_W-1:0] p,
                                                  input logic [PSC_W-1:0] lim);
    return (p == lim) ? '0 : p + PSC_W'(1);
  endfunction

  assign tick = run && !clr && (pcnt == psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      psc_act <= '0;
    end else begin
      if (clr)      pcnt <= '0;
      else if (run) pcnt <= phase_next(pcnt, psc_act);
      if (uev)      psc_act <= psc_buf;
    end
  end

  a_r4_phase_within_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= psc_act);

  a_r10_frozen_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcnt));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input logic wrap);
    return wrap ? '0 : c + CNT_W'(1);
  endfunction

  assign ovf = tick && (cnt == arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (tick)   cnt <= count_next(cnt, ovf);
  end

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf && !load && !clr) |=> (cnt == $past(cnt) + CNT_W'(1)));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !load) |=> (cnt == '0));

  a_r8_sw_update_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/base_timer.sv
module base_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  input  logic              dbg_freeze_en,
  output logic              upd_evt,
  output logic              upd_irq
);

  ctrl_t            ctrl;
  logic [PSC_W-1:0] psc_buf;
  logic [CNT_W-1:0] arr_buf, arr_act, cnt, cnt_load_val;
  logic             sw_ug, cnt_load, stat_clr;
  logic             run, tick, ovf, uev, flag_set, uif, evt_q;

  // Named internal events.
  assign run      = ctrl.cen && !(dbg_halt && dbg_freeze_en);
  assign uev      = (ovf || sw_ug) && !ctrl.udis;
  assign flag_set = uev && (ovf || !ctrl.urs);

  tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .uev(uev), .ctrl(ctrl),
    .psc_buf(psc_buf), .arr_buf(arr_buf), .arr_act(arr_act), .sw_ug(sw_ug),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .stat_clr(stat_clr)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(sw_ug), .uev(uev),
    .psc_buf(psc_buf), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(sw_ug), .load(cnt_load),
    .load_val(cnt_load_val), .arr_act(arr_act), .cnt(cnt), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uif   <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= uev;
      if (flag_set)      uif <= 1'b1;
      else if (stat_clr) uif <= 1'b0;
    end
  end

  assign upd_evt = evt_q;
  assign upd_irq = uif;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): bus_rdata[REG_DW-1:0] = ctrl_encode(ctrl);
      ADDR_W'(OFS_STAT): bus_rdata[0]          = uif;
      ADDR_W'(OFS_CNT):  bus_rdata[CNT_W-1:0]  = cnt;
      ADDR_W'(OFS_PSC):  bus_rdata[PSC_W-1:0]  = psc_buf;
      ADDR_W'(OFS_ARR):  bus_rdata[CNT_W-1:0]  = arr_buf;
      default:           bus_rdata             = '0;
    endcase
  end

  a_r6_blocked_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.udis |=> !upd_evt);

  a_r7_sw_update_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ug && ctrl.urs && !uif) |=> !uif);

  a_r12_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !flag_set) |=> !upd_irq);

endmodule

// File: tb/sim_base_timer.sv
`timescale 1ns/100ps
module sim_base_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [1:0]  b_size = 2'd2;
  logic [31:0] b_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        dbg_freeze = 1'b0;
  logic        upd_evt, upd_irq;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_cen, m_udis, m_urs, m_opm, m_arpe;
  int m_pcnt, m_psc_act, m_psc_buf, m_cnt, m_arr_act, m_arr_buf, m_uif, m_evt;

  always #2.5 clk = ~clk;

  base_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we),
    .bus_size(b_size), .bus_wdata(b_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze),
    .upd_evt(upd_evt), .upd_irq(upd_irq)
  );

  task automatic model_reset();
    m_cen = 0; m_udis = 0; m_urs = 0; m_opm = 0; m_arpe = 0;
    m_pcnt = 0; m_psc_act = 0; m_psc_buf = 0; m_cnt = 0;
    m_arr_act = 'hFFFF; m_arr_buf = 'hFFFF; m_uif = 0; m_evt = 0;
  endtask

  function automatic int model_read(input int a);
    case (a)
      'h00: return m_cen | (m_udis << 1) | (m_urs << 2) | (m_opm << 3) | (m_arpe << 7);
      'h08: return m_uif;
      'h0C: return m_cnt;
      'h10: return m_psc_buf;
      'h14: return m_arr_buf;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit accept, swu, running, tk, wrap, upd;
    int wd, n_pcnt, n_cnt, n_arr_act, n_cen;
    wd      = b_wdata & 'hFFFF;
    accept  = b_we && (b_size == 2'd1 || b_size == 2'd2);
    swu     = accept && b_addr == 5'h04 && b_wdata[0];
    running = m_cen != 0 && !(dbg_halt && dbg_freeze);
    tk = 0;
    n_pcnt = m_pcnt;
    if (swu) n_pcnt = 0;
    else if (running) begin
      if (m_pcnt == m_psc_act) begin tk = 1; n_pcnt = 0; end
      else n_pcnt = m_pcnt + 1;
    end
    wrap = tk && (m_cnt == m_arr_act);
    upd  = (wrap || swu) && m_udis == 0;
    n_cnt = m_cnt;
    if (swu) n_cnt = 0;
    else if (accept && b_addr == 5'h0C) n_cnt = wd;
    else if (tk) n_cnt = wrap ? 0 : m_cnt + 1;
    n_arr_act = m_arr_act;
    if (upd) n_arr_act = m_arr_buf;
    if (accept && b_addr == 5'h14 && m_arpe == 0) n_arr_act = wd;
    if (upd) m_psc_act = m_psc_buf;
    if (accept && b_addr == 5'h10) m_psc_buf = wd;
    if (accept && b_addr == 5'h14) m_arr_buf = wd;
    n_cen = m_cen;
    if (upd && m_opm != 0) n_cen = 0;
    if (accept && b_addr == 5'h00) begin
      m_udis = wd[1]; m_urs = wd[2]; m_arpe = wd[7];
      n_cen = (upd && m_opm != 0) ? 0 : wd[0];
      m_opm = wd[3];
    end
    m_cen = n_cen;
    if (upd && (wrap || m_urs == 0)) m_uif = 1;
    else if (accept && b_addr == 5'h08 && !b_wdata[0]) m_uif = 0;
    m_evt = upd;
    m_pcnt = n_pcnt; m_cnt = n_cnt; m_arr_act = n_arr_act;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: apply inputs at negedge, advance model, compare at next negedge.
  task automatic cyc(input string tag, input bit we, input int a, input int sz, input int wd);
    b_we = we; b_addr = a[4:0]; b_size = sz[1:0]; b_wdata = wd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, "rdata", int'(bus_rdata), model_read(a));
    check(tag, "upd_evt", int'(upd_evt), m_evt);
    check(tag, "upd_irq", int'(upd_irq), m_uif);
  endtask

  task automatic wr(input string tag, input int a, input int wd);
    cyc(tag, 1'b1, a, 2, wd);
  endtask

  task automatic idle(input string tag, input int n, input int a);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, a, 2, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1: got hung run expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values on every register
    idle("R1", 1, 'h00); idle("R1", 1, 'h04); idle("R1", 1, 'h08);
    idle("R1", 1, 'h0C); idle("R1", 1, 'h10); idle("R1", 1, 'h14);

    // R4 prescaler buffered, R3 counting, R8 software update, R12 flag
    wr("R4", 'h10, 2);
    idle("R4", 4, 'h0C);
    cyc("R4", 1'b1, 'h14, 1, 4);
    wr("R3", 'h00, 'h01);
    idle("R3", 12, 'h0C);
    wr("R8", 'h04, 1);
    idle("R8", 1, 'h04);
    idle("R4", 20, 'h0C);
    idle("R12", 1, 'h08);
    wr("R12", 'h08, 1);
    idle("R12", 1, 'h08);
    wr("R12", 'h08, 0);
    idle("R12", 2, 'h08);

    // R5 reload buffering on and off, R13 counter load
    wr("R5", 'h00, 'h81);
    wr("R5", 'h14, 7);
    idle("R5", 2, 'h14);
    idle("R5", 40, 'h0C);
    wr("R5", 'h00, 'h01);
    wr("R5", 'h14, 2);
    idle("R5", 12, 'h0C);
    wr("R13", 'h0C, 1);
    idle("R13", 6, 'h0C);

    // R6 update block: prescaler change must not transfer
    wr("R6", 'h00, 'h03);
    wr("R6", 'h10, 0);
    idle("R6", 24, 'h0C);
    wr("R6", 'h04, 1);
    idle("R6", 6, 'h0C);
    wr("R6", 'h00, 'h01);
    idle("R6", 12, 'h0C);

    // R7 overflow-only flag source
    wr("R7", 'h00, 'h05);
    wr("R7", 'h08, 0);
    wr("R7", 'h04, 1);
    idle("R7", 2, 'h08);
    idle("R7", 8, 'h08);

    // R9 one-shot
    wr("R9", 'h08, 0);
    wr("R9", 'h14, 3);
    wr("R9", 'h00, 'h09);
    idle("R9", 10, 'h0C);
    idle("R9", 3, 'h00);

    // R10 debug freeze
    wr("R10", 'h00, 'h01);
    idle("R10", 3, 'h0C);
    dbg_halt = 1'b1; dbg_freeze = 1'b1;
    idle("R10", 8, 'h0C);
    dbg_freeze = 1'b0;
    idle("R10", 8, 'h0C);
    dbg_halt = 1'b0;
    idle("R10", 4, 'h0C);

    // R11 narrow and reserved-size writes refused
    cyc("R11", 1'b1, 'h00, 0, 'h00);
    cyc("R11", 1'b1, 'h14, 0, 'h09);
    cyc("R11", 1'b1, 'h10, 3, 'h05);
    cyc("R11", 1'b1, 'h0C, 0, 'h00);
    idle("R11", 1, 'h00); idle("R11", 1, 'h14); idle("R11", 1, 'h10);
    idle("R11", 2, 'h0C);

    // R2 control layout, reserved bits read zero
    wr("R2", 'h00, 'hFFFF_FFFF);
    idle("R2", 3, 'h00);
    wr("R2", 'h00, 'h0000);
    idle("R2", 3, 'h00);
    idle("R1", 2, 'h0C);

    finish_run();
  end

endmodule